// File: doc/BRIEF.md
# Local Bus Cycle Strobe Sequencer

This block turns single transfer requests from a processor core into the pin-level strobe sequence of a multiplexed local bus. Each bus cycle passes through the T-states T1, T2, T3, zero or more wait states TW, and T4. The internal clock runs at twice the T-state rate, so every T-state lasts two clocks: a first half and a second half. Address latch enable rises half a T-state before T1 begins and falls halfway through T1. The address is driven during that window and released before any read strobe can assert. Read and write strobes cover the data phase. An active-low upper-byte enable, together with address bit 0, tells the system which byte lanes the transfer uses, or that the cycle is a refresh.

The core offers a request on a valid/ready pair. It carries an address, a word/byte size flag, a direction and a refresh flag. `req_ready` depends only on the sequencer state, on `hold_req` and on reset, and never on `req_valid`. A request is taken in a clock where both `req_valid` and `req_ready` are high. The core must hold the request fields stable while `req_valid` is high and `req_ready` is low. An external master can take the bus through `hold_req` and `hold_ack`. While the bus is held, every tri-stated pin has its output enable low. Each tri-state pin is modelled as a value plus a separate output enable.

When reset is asserted, the read and write pins are driven high for one clock and then released. During reset the read pin strap is sampled. If it is tied low, the sequencer enters queue-status mode: the ALE and write pins carry the core's two-bit queue status instead of strobes.

Top module: `lbus_strobe_seq`

## Requirements
- R1: `req_ready` is high only outside reset, with `hold_req` low, and only while the bus is idle or in the second half of T4. A request taken at a clock edge puts the bus into the launch half-state, the half-state immediately before T1, for the next clock.
- R2: `ale_qs0` (normal mode) is high for exactly the launch half-state and the first half of T1. `addr_oe` is high from the launch half-state through the end of T1, with `addr_o` = {request address bits AW-1..1, A0 code}. The address is released from T2 onward.
- R3: For a read or refresh cycle, `rd_n` is low from the second half of T2 through T3 and every TW, and is high otherwise. `rd_n` is never low while `addr_oe` is high, nor in the clock after `addr_oe` was high.
- R4: For a write cycle, `wr_n_qs1` is low for the whole of T2, T3 and every TW, and is high otherwise. Read and write are never low together.
- R5: `bus_rdy` is sampled only at the edge that ends the second half of T3 or of a TW. Each low sample inserts one TW of two clocks, and a high sample moves the bus to T4. Its value at every other edge has no effect.
- R6: The lane code {`bhe_n`, A0} is 2'b00 for a word, 2'b01 for a byte at an odd address, 2'b10 for a byte at an even address, and 2'b11 for a refresh. A refresh runs as a read. `bhe_n` carries this code from T1 through the last TW, and is high in all other states.
- R7: Hold is granted only from idle or at the end of T4, and it takes priority over a pending request. While the bus is held, `hold_ack` is 1 and `rd_oe`, `bhe_oe` and `addr_oe` are 0. `wr_oe` is also 0 in normal mode. The ALE pin stays driven and low.
- R8: One clock after `hold_req` falls, the bus is idle, `hold_ack` is 0 and `req_ready` is high.
- R9: In the first clock of a reset that follows a clock without reset, `rd_oe` and `wr_oe` are 1 with `rd_n` and `wr_n_qs1` high. In later reset clocks both enables are 0, and `req_ready`, `addr_oe`, `bhe_oe` and the ALE pin are all 0.
- R10: `rd_strap` is sampled in reset clocks after the first. If it was low at reset exit, the mode is queue status: `ale_qs0` = `qs_in[0]` and `wr_n_qs1` = `qs_in[1]`, each registered one clock. `wr_oe` is 1 and `rd_oe` is 0. The mode does not change outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two clocks per T-state |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | AW | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word transfer, 0 = byte |
| req_refresh | input | 1 | 1 = refresh cycle (overrides size and direction) |
| bus_rdy | input | 1 | Synchronous ready from the addressed device |
| hold_req | input | 1 | External bus hold request |
| hold_ack | output | 1 | Bus is released to the external master |
| qs_in | input | 2 | Queue status from the core, {QS1,QS0} |
| rd_strap | input | 1 | Level seen on the read pin during reset |
| addr_o | output | AW | Address/lane pins value |
| addr_oe | output | 1 | Address pins output enable |
| ale_qs0 | output | 1 | ALE, or QS0 in queue mode (never floated) |
| rd_n | output | 1 | Read strobe value, active low |
| rd_oe | output | 1 | Read pin output enable |
| wr_n_qs1 | output | 1 | Write strobe value, or QS1 in queue mode |
| wr_oe | output | 1 | Write pin output enable |
| bhe_n | output | 1 | Upper-byte enable value, active low |
| bhe_oe | output | 1 | Upper-byte enable output enable |

## Verification
A wrong T-state or phase shows up at the pins within one clock. It appears as ALE, a strobe or the address enable switching one half-state early or late, so the bench compares every pin in every half-state of each cycle against a timeline built from the cycle index and the wait count. A wrongly sampled `bus_rdy` stretches or shortens the data phase by two clocks, and the bench catches this when it checks T4. A wrong latched lane code is visible from T1 onward on `bhe_n` and the A0 bit. A wrong mode latched at reset shows on the first clock after reset exit, when queue status fails to appear on the ALE and write pins.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TA   = 3'd1,
    ST_T1   = 3'd2,
    ST_T2   = 3'd3,
    ST_T3   = 3'd4,
    ST_TW   = 3'd5,
    ST_T4   = 3'd6,
    ST_HOLD = 3'd7
  } bus_st_e;

  localparam logic [1:0] LANE_WORD    = 2'b00;
  localparam logic [1:0] LANE_ODD     = 2'b01;
  localparam logic [1:0] LANE_EVEN    = 2'b10;
  localparam logic [1:0] LANE_REFRESH = 2'b11;

  // Returns {bhe_n, a0} for a transfer.
  function automatic logic [1:0] lane_code(input logic word, input logic refresh,
                                           input logic addr0);
    if (refresh)    return LANE_REFRESH;
    else if (word)  return LANE_WORD;
    else if (addr0) return LANE_ODD;
    else            return LANE_EVEN;
  endfunction

  function automatic logic in_data_phase(input bus_st_e st);
    return (st == ST_T2) || (st == ST_T3) || (st == ST_TW);
  endfunction

endpackage

// File: rtl/lbs_rst_strap.sv
module lbs_rst_strap (
  input  logic clk,
  input  logic rst,
  input  logic rd_strap,
  output logic drive_hi,
  output logic qmode
);
  logic rst_q;
  logic qmode_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst && rst_q) qmode_q <= ~rd_strap;
  end

  // First clock of a fresh reset: pins are driven high, strap not sampled.
  assign drive_hi = rst && !rst_q;
  assign qmode    = qmode_q;

  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(qmode_q)); // R10

endmodule

// File: rtl/lbs_cycle_fsm.sv
module lbs_cycle_fsm
  import lbs_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_word,
  input  logic          req_refresh,
  input  logic          bus_rdy,
  input  logic          hold_req,
  output bus_st_e       st,
  output logic          ph,
  output logic [AW-1:0] cur_addr,
  output logic          cur_write,
  output logic          cur_bhe_n
);
  bus_st_e       st_q, st_d;
  logic          ph_q, ph_d;
  logic [AW-1:0] addr_q;
  logic          wr_q;
  logic [1:0]    code_q;
  logic          boundary;
  logic          take;

  assign boundary  = (st_q == ST_IDLE) || ((st_q == ST_T4) && ph_q);
  assign req_ready = !rst && boundary && !hold_req;
  assign take      = req_valid && req_ready;

  always_comb begin
    st_d = st_q;
    ph_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (hold_req)       st_d = ST_HOLD;
        else if (req_valid) st_d = ST_TA;
      end
      ST_TA: st_d = ST_T1;
      ST_T1: if (!ph_q) ph_d = 1'b1; else st_d = ST_T2;
      ST_T2: if (!ph_q) ph_d = 1'b1; else st_d = ST_T3;
      ST_T3, ST_TW: begin
        if (!ph_q) ph_d = 1'b1;
        else       st_d = bus_rdy ? ST_T4 : ST_TW;
      end
      ST_T4: begin
        if (!ph_q)          ph_d = 1'b1;
        else if (hold_req)  st_d = ST_HOLD;
        else if (req_valid) st_d = ST_TA;
        else                st_d = ST_IDLE;
      end
      ST_HOLD: if (!hold_req) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      ph_q   <= 1'b0;
      addr_q <= '0;
      wr_q   <= 1'b0;
      code_q <= LANE_REFRESH;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
      if (take) begin
        addr_q <= req_addr;
        wr_q   <= req_write && !req_refresh;
        code_q <= lane_code(req_word, req_refresh, req_addr[0]);
      end
    end
  end

  assign st        = st_q;
  assign ph        = ph_q;
  assign cur_addr  = {addr_q[AW-1:1], code_q[0]};
  assign cur_write = wr_q;
  assign cur_bhe_n = code_q[1];

  AST_ACCEPT_TO_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (st_q == ST_TA)); // R1

  AST_HOLD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q == ST_HOLD) |-> $past(boundary)); // R7

  AST_WAIT_NEEDS_LOW_RDY: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_TW) && !ph_q) |-> $past(!bus_rdy)); // R5

endmodule

// File: rtl/lbs_pin_drive.sv
module lbs_pin_drive
  import lbs_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          drive_hi,
  input  logic          qmode,
  input  bus_st_e       st,
  input  logic          ph,
  input  logic [AW-1:0] cur_addr,
  input  logic          cur_write,
  input  logic          cur_bhe_n,
  input  logic [1:0]    qs_in,
  output logic [AW-1:0] addr_o,
  output logic          addr_oe,
  output logic          ale_qs0,
  output logic          rd_n,
  output logic          rd_oe,
  output logic          wr_n_qs1,
  output logic          wr_oe,
  output logic          bhe_n,
  output logic          bhe_oe
);
  logic [1:0] qs_q;
  logic       ale_int, rd_low, wr_low, bhe_win, holding, addr_win;

  always_ff @(posedge clk) begin
    if (rst) qs_q <= 2'b00;
    else     qs_q <= qs_in;
  end

  assign holding  = (st == ST_HOLD);
  assign ale_int  = (st == ST_TA) || ((st == ST_T1) && !ph);
  assign addr_win = (st == ST_TA) || (st == ST_T1);
  assign wr_low   = cur_write && in_data_phase(st);
  assign rd_low   = !cur_write && (((st == ST_T2) && ph) || (st == ST_T3) || (st == ST_TW));
  assign bhe_win  = (st == ST_T1) || in_data_phase(st);

  assign addr_o = cur_addr;

  always_comb begin
    if (rst) begin
      addr_oe  = 1'b0;
      ale_qs0  = 1'b0;
      rd_n     = 1'b1;
      rd_oe    = drive_hi;
      wr_n_qs1 = 1'b1;
      wr_oe    = drive_hi;
      bhe_n    = 1'b1;
      bhe_oe   = 1'b0;
    end else begin
      addr_oe  = addr_win;
      ale_qs0  = qmode ? qs_q[0] : ale_int;
      rd_n     = !rd_low;
      rd_oe    = !qmode && !holding;
      wr_n_qs1 = qmode ? qs_q[1] : !wr_low;
      wr_oe    = qmode || !holding;
      bhe_n    = bhe_win ? cur_bhe_n : 1'b1;
      bhe_oe   = !holding;
    end
  end

  AST_RD_AFTER_FLOAT: assert property (@(posedge clk) disable iff (rst)
    (rd_oe && !rd_n) |-> (!addr_oe && $past(!addr_oe))); // R3

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !qmode |-> !(!rd_n && !wr_n_qs1)); // R4

  AST_ALE_TWO_HALVES: assert property (@(posedge clk) disable iff (rst)
    (!qmode && $rose(ale_qs0)) |=> (ale_qs0 && addr_oe)); // R2

  AST_HOLD_FLOAT: assert property (@(posedge clk) disable iff (rst)
    holding |-> (!rd_oe && !bhe_oe && !addr_oe)); // R7

endmodule

// File: rtl/lbus_strobe_seq.sv
module lbus_strobe_seq
  import lbs_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_word,
  input  logic          req_refresh,
  input  logic          bus_rdy,
  input  logic          hold_req,
  output logic          hold_ack,
  input  logic [1:0]    qs_in,
  input  logic          rd_strap,
  output logic [AW-1:0] addr_o,
  output logic          addr_oe,
  output logic          ale_qs0,
  output logic          rd_n,
  output logic          rd_oe,
  output logic          wr_n_qs1,
  output logic          wr_oe,
  output logic          bhe_n,
  output logic          bhe_oe
);
  bus_st_e       st;
  logic          ph;
  logic [AW-1:0] cur_addr;
  logic          cur_write, cur_bhe_n;
  logic          drive_hi, qmode;

  lbs_rst_strap u_strap (
    .clk      (clk),
    .rst      (rst),
    .rd_strap (rd_strap),
    .drive_hi (drive_hi),
    .qmode    (qmode)
  );

  lbs_cycle_fsm #(.AW(AW)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_write   (req_write),
    .req_word    (req_word),
    .req_refresh (req_refresh),
    .bus_rdy     (bus_rdy),
    .hold_req    (hold_req),
    .st          (st),
    .ph          (ph),
    .cur_addr    (cur_addr),
    .cur_write   (cur_write),
    .cur_bhe_n   (cur_bhe_n)
  );

  lbs_pin_drive #(.AW(AW)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .drive_hi  (drive_hi),
    .qmode     (qmode),
    .st        (st),
    .ph        (ph),
    .cur_addr  (cur_addr),
    .cur_write (cur_write),
    .cur_bhe_n (cur_bhe_n),
    .qs_in     (qs_in),
    .addr_o    (addr_o),
    .addr_oe   (addr_oe),
    .ale_qs0   (ale_qs0),
    .rd_n      (rd_n),
    .rd_oe     (rd_oe),
    .wr_n_qs1  (wr_n_qs1),
    .wr_oe     (wr_oe),
    .bhe_n     (bhe_n),
    .bhe_oe    (bhe_oe)
  );

  assign hold_ack = !rst && (st == ST_HOLD);

  AST_ACK_NO_READY: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> !req_ready); // R7

endmodule

// File: tb/test_lbus_strobe_seq.sv
module test_lbus_strobe_seq;
  localparam int AW = 20;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0, req_refresh = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          bus_rdy = 1'b1, hold_req = 1'b0, rd_strap = 1'b1;
  logic [1:0]    qs_in = 2'b00;
  logic          req_ready, hold_ack, addr_oe, ale_qs0, rd_n, rd_oe, wr_n_qs1, wr_oe, bhe_n, bhe_oe;
  logic [AW-1:0] addr_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbus_strobe_seq #(.AW(AW)) i_lbus_strobe_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_word(req_word),
    .req_refresh(req_refresh), .bus_rdy(bus_rdy), .hold_req(hold_req),
    .hold_ack(hold_ack), .qs_in(qs_in), .rd_strap(rd_strap), .addr_o(addr_o),
    .addr_oe(addr_oe), .ale_qs0(ale_qs0), .rd_n(rd_n), .rd_oe(rd_oe),
    .wr_n_qs1(wr_n_qs1), .wr_oe(wr_oe), .bhe_n(bhe_n), .bhe_oe(bhe_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // {bhe_n, a0} per R6
  function automatic logic [1:0] exp_code(input bit word, input bit rfs, input bit a0);
    if (rfs)       return 2'b11;
    else if (word) return 2'b00;
    else if (a0)   return 2'b01;
    else           return 2'b10;
  endfunction

  // {ale, addr_oe, rd_n, wr_n, bhe_n} at half-state k after acceptance (k=0 launch)
  function automatic logic [4:0] exp_pins(input int k, input int w, input bit wr,
                                          input logic [1:0] code);
    int last_data = 6 + 2*w;
    logic ale  = (k <= 1);
    logic aoe  = (k <= 2);
    logic rdn  = !(!wr && k >= 4 && k <= last_data);
    logic wrn  = !(wr && k >= 3 && k <= last_data);
    logic bhen = (k >= 1 && k <= last_data) ? code[1] : 1'b1;
    return {ale, aoe, rdn, wrn, bhen};
  endfunction

  task automatic run_cycle(input logic [AW-1:0] a, input bit wr, input bit word,
                           input bit rfs, input int w, input bit hold_mid);
    logic [1:0] code = exp_code(word, rfs, a[0]);
    bit         eff_wr = wr && !rfs;
    int         kend = 8 + 2*w;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1", "ready when idle", {31'd0, req_ready}, 1);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_word = word; req_refresh = rfs;
    for (int k = 0; k <= kend; k++) begin
      @(negedge clk);
      if (k == 0) begin
        req_valid = 1'b0;
        req_addr = AW'($urandom); req_write = 1'($urandom); req_word = 1'($urandom);
        req_refresh = 1'($urandom);
      end
      chk({ale_qs0, addr_oe, rd_n, wr_n_qs1, bhe_n} === exp_pins(k, w, eff_wr, code),
          "R2 R3 R4 R5 R6", $sformatf("pins at half %0d", k),
          {27'd0, ale_qs0, addr_oe, rd_n, wr_n_qs1, bhe_n}, {27'd0, exp_pins(k, w, eff_wr, code)});
      if (k <= 2)
        chk(addr_o === {a[AW-1:1], code[0]}, "R2 R6", "address with A0 code",
            32'(addr_o), 32'({a[AW-1:1], code[0]}));
      if (k >= 6 && ((k - 6) % 2 == 0) && ((k - 6) / 2 <= w))
        bus_rdy = ((k - 6) / 2 == w);
      else
        bus_rdy = 1'($urandom);
      if (hold_mid && k == 2) hold_req = 1'b1;
      if (k >= 1 && k < kend)
        chk(req_ready === 1'b0, "R1", "ready low mid-cycle", {31'd0, req_ready}, 0);
    end
    chk(req_ready === !hold_mid, "R1 R7", "ready at end of T4", {31'd0, req_ready}, {31'd0, !hold_mid});
    if (hold_mid) begin
      @(negedge clk);
      chk(hold_ack === 1'b1 && rd_oe === 1'b0 && wr_oe === 1'b0 && bhe_oe === 1'b0 &&
          addr_oe === 1'b0 && ale_qs0 === 1'b0, "R7", "hold float after T4",
          {26'd0, hold_ack, rd_oe, wr_oe, bhe_oe, addr_oe, ale_qs0}, 32'h20);
      hold_req = 1'b0;
      @(negedge clk);
      chk(hold_ack === 1'b0 && req_ready === 1'b1, "R8", "release from hold",
          {30'd0, hold_ack, req_ready}, 1);
    end
  endtask

  task automatic do_reset(input bit strap);
    @(negedge clk);
    rst = 1'b1; rd_strap = strap;
    #1;
    chk(rd_oe === 1'b1 && rd_n === 1'b1 && wr_oe === 1'b1 && wr_n_qs1 === 1'b1, "R9",
        "first reset clock drives high", {28'd0, rd_oe, rd_n, wr_oe, wr_n_qs1}, 32'hF);
    @(negedge clk);
    chk(rd_oe === 1'b0 && wr_oe === 1'b0, "R9", "strobes released in reset",
        {30'd0, rd_oe, wr_oe}, 0);
    chk(req_ready === 1'b0 && addr_oe === 1'b0 && bhe_oe === 1'b0 && ale_qs0 === 1'b0, "R9",
        "reset state", {28'd0, req_ready, addr_oe, bhe_oe, ale_qs0}, 0);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    rd_strap = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1931));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1 && hold_ack === 1'b0 && rd_oe === 1'b1 && bhe_oe === 1'b1 &&
        ale_qs0 === 1'b0, "R1", "state after reset",
        {27'd0, req_ready, hold_ack, rd_oe, bhe_oe, ale_qs0}, 32'h16);

    // R6 directed: each lane code, R5 with 0 and 2 waits
    run_cycle(20'h12344, 1'b0, 1'b1, 1'b0, 0, 1'b0);
    run_cycle(20'h0ABC1, 1'b1, 1'b0, 1'b0, 2, 1'b0);
    run_cycle(20'h0ABC0, 1'b0, 1'b0, 1'b0, 1, 1'b0);
    run_cycle(20'hFFFFF, 1'b1, 1'b1, 1'b1, 0, 1'b0);  // refresh runs as read
    // R7 hold requested mid-cycle, granted only after T4
    run_cycle(20'h55555, 1'b1, 1'b0, 1'b0, 1, 1'b1);

    // R7 hold wins over a waiting request while idle
    @(negedge clk);
    hold_req = 1'b1; req_valid = 1'b1;
    #1;
    chk(req_ready === 1'b0, "R7", "hold priority over request", {31'd0, req_ready}, 0);
    @(negedge clk);
    chk(hold_ack === 1'b1 && rd_oe === 1'b0 && wr_oe === 1'b0, "R7", "hold from idle",
        {29'd0, hold_ack, rd_oe, wr_oe}, 4);
    req_valid = 1'b0; hold_req = 1'b0;
    @(negedge clk);
    chk(hold_ack === 1'b0 && req_ready === 1'b1, "R8", "idle after hold", {30'd0, hold_ack, req_ready}, 1);

    // random cycles in normal mode
    for (int i = 0; i < 40; i++) begin
      run_cycle(AW'($urandom), 1'($urandom), 1'($urandom), ($urandom % 6) == 0,
                int'($urandom % 4), ($urandom % 5) == 0);
      if ($urandom % 2) @(negedge clk);
    end

    // R10 queue status mode
    do_reset(1'b0);
    for (int v = 0; v < 4; v++) begin
      qs_in = 2'(v);
      @(negedge clk);
      chk(ale_qs0 === qs_in[0] && wr_n_qs1 === qs_in[1] && wr_oe === 1'b1 && rd_oe === 1'b0,
          "R10", "queue status on pins", {28'd0, ale_qs0, wr_n_qs1, wr_oe, rd_oe},
          {28'd0, qs_in[0], qs_in[1], 2'b10});
    end

    // back to normal mode, R9 checked again in do_reset
    do_reset(1'b1);
    @(negedge clk);
    chk(rd_oe === 1'b1 && wr_n_qs1 === 1'b1, "R10", "normal mode restored", {30'd0, rd_oe, wr_n_qs1}, 3);
    run_cycle(20'h00101, 1'b0, 1'b0, 1'b0, 3, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule